// File: doc/BRIEF.md
# Ready/Valid Channel Protocol Monitor

This block watches a single point-to-point link that moves a data word under a ready/valid handshake, with every signal in one clock domain. It never drives the link. In each cycle it sorts the channel into one of three conditions. In a transfer cycle both valid and ready are high. In a wait cycle a word is offered but is not taken. In an idle cycle no word is offered. It also keeps a running count of transfers and a running count of stalled cycles.

The sender may raise valid before the receiver is ready. After it has offered a word, however, it must keep that word and its valid unchanged until the word is taken. The monitor stores the word seen in each wait cycle and compares it with the word in the following cycle. It raises a sticky flag when the data changes and a separate sticky flag when valid is withdrawn. Integration logic or a test environment reads these flags to catch senders that break the protocol.

Top module: `rv_chan_monitor`

## Requirements
- R1: `chanState` is combinational from the current inputs and is encoded as 2'b10 when valid and ready are both 1 (transfer), 2'b01 when valid is 1 and ready is 0 (wait), and 2'b00 in every other case (idle, including valid 0 with ready 1 and valid 0 with ready 0).
- R2: `xferCount` goes up by exactly one after each clock edge that ends a transfer cycle. Transfers in back-to-back cycles are each counted.
- R3: `waitCount` goes up by exactly one after each clock edge that ends a wait cycle. Idle cycles change neither counter.
- R4: Both counters saturate at 2^CNT_W-1 (255 with the default CNT_W of 8) and then hold that value.
- R5: Raising valid before ready, and then completing the handshake with the same data, sets neither error flag.
- R6: When a wait cycle is followed by a cycle with valid 1 and data different from the data of the wait cycle, `dataErr` is set at the edge that ends the second cycle. The flag then stays set until reset.
- R7: When a wait cycle is followed by a cycle with valid 0, `validErr` is set at the edge that ends that cycle and stays set until reset. This case does not set `dataErr`.
- R8: After a transfer cycle the sender may change the data or drop valid in the next cycle without setting either flag.
- R9: A synchronous active-high `rst` clears both counters and both flags. It also discards any pending word, so data offered after reset is not compared with data from before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the monitored link |
| rst | input | 1 | Synchronous active-high reset |
| linkValid | input | 1 | Valid signal observed on the link |
| linkReady | input | 1 | Ready signal observed on the link |
| linkData | input | DATA_W | Data word observed on the link |
| chanState | output | 2 | Classification of the current cycle |
| xferCount | output | CNT_W | Saturating count of transfers |
| waitCount | output | CNT_W | Saturating count of wait cycles |
| dataErr | output | 1 | Sticky flag for data changed while a word was pending |
| validErr | output | 1 | Sticky flag for valid withdrawn while a word was pending |

## Verification
The channel state is a same-cycle result. The bench drives the inputs just after a falling edge and reads `chanState` one time unit later, before the next rising edge. The counters and both flags each pass through a single register. They are due after the rising edge that ends the cycle being judged, so the bench samples them one time unit after that edge. A scoreboard built from the requirements predicts every value for the same sample points.

// File: rtl/rvmon_pkg.sv
package rvmon_pkg;

  typedef enum logic [1:0] {
    CH_IDLE = 2'b00,
    CH_WAIT = 2'b01,
    CH_XFER = 2'b10
  } chan_e;

  typedef struct packed {
    logic incXfer;    // transfer cycle
    logic incWait;    // wait cycle
    logic holdWord;   // store the offered word
    logic checkWord;  // word pending, valid still high: compare
    logic validDrop;  // word pending, valid withdrawn
  } mon_strobe_t;

endpackage

// File: rtl/rvmon_ctrl.sv
module rvmon_ctrl
  import rvmon_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        linkValid,
  input  logic        linkReady,
  output chan_e       chanState,
  output mon_strobe_t strobe
);

  logic isXfer;
  logic isWait;
  logic pending;

  assign isXfer = linkValid && linkReady;
  assign isWait = linkValid && !linkReady;

  always_comb begin
    if (isXfer)      chanState = CH_XFER;
    else if (isWait) chanState = CH_WAIT;
    else             chanState = CH_IDLE;
  end

  // pending: previous cycle offered a word that was not taken
  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= isWait;
  end

  always_comb begin
    strobe           = '0;
    strobe.incXfer   = isXfer;
    strobe.incWait   = isWait;
    strobe.holdWord  = isWait;
    strobe.checkWord = pending && linkValid;
    strobe.validDrop = pending && !linkValid;
  end

  // R7: a withdrawn valid can only follow a wait cycle
  assert_drop_after_wait_R7: assert property (@(posedge clk) disable iff (rst)
    strobe.validDrop |-> !$past(linkReady) && $past(linkValid));

endmodule

// File: rtl/rvmon_satcnt.sv
module rvmon_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                          count <= '0;
    else if (inc && count != MAX_VAL) count <= count + 1'b1;
  end

  // R2 / R3: the count never moves by more than one per cycle
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (count == $past(count)) || (count == W'($past(count) + 1'b1)));

  // R4: once full, it stays full
  assert_sat_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (count == MAX_VAL) |=> (count == MAX_VAL));

endmodule

// File: rtl/rvmon_dpath.sv
module rvmon_dpath
  import rvmon_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] linkData,
  input  mon_strobe_t       strobe,
  output logic [CNT_W-1:0]  xferCount,
  output logic [CNT_W-1:0]  waitCount,
  output logic              dataErr,
  output logic              validErr
);

  localparam int NUM_CNT = 2;

  logic [DATA_W-1:0] heldWord;
  logic              wordMoved;
  logic [NUM_CNT-1:0] incVec;
  logic [CNT_W-1:0]   cntVec [NUM_CNT];

  always_ff @(posedge clk) begin
    if (rst)                  heldWord <= '0;
    else if (strobe.holdWord) heldWord <= linkData;
  end

  assign wordMoved = strobe.checkWord && (linkData != heldWord);

  always_ff @(posedge clk) begin
    if (rst) begin
      dataErr  <= 1'b0;
      validErr <= 1'b0;
    end else begin
      if (wordMoved)        dataErr  <= 1'b1;
      if (strobe.validDrop) validErr <= 1'b1;
    end
  end

  assign incVec = {strobe.incWait, strobe.incXfer};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    rvmon_satcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (incVec[i]),
      .count (cntVec[i])
    );
  end

  assign xferCount = cntVec[0];
  assign waitCount = cntVec[1];

  assert_sticky_data_R6: assert property (@(posedge clk) disable iff (rst)
    dataErr |=> dataErr);

  assert_sticky_valid_R7: assert property (@(posedge clk) disable iff (rst)
    validErr |=> validErr);

endmodule

// File: rtl/rv_chan_monitor.sv
module rv_chan_monitor
  import rvmon_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              linkValid,
  input  logic              linkReady,
  input  logic [DATA_W-1:0] linkData,
  output logic [1:0]        chanState,
  output logic [CNT_W-1:0]  xferCount,
  output logic [CNT_W-1:0]  waitCount,
  output logic              dataErr,
  output logic              validErr
);

  chan_e       stateEnum;
  mon_strobe_t strobe;

  rvmon_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .linkValid (linkValid),
    .linkReady (linkReady),
    .chanState (stateEnum),
    .strobe    (strobe)
  );

  rvmon_dpath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .linkData  (linkData),
    .strobe    (strobe),
    .xferCount (xferCount),
    .waitCount (waitCount),
    .dataErr   (dataErr),
    .validErr  (validErr)
  );

  assign chanState = stateEnum;

  // R1: the unused code 2'b11 never appears
  assert_state_code_R1: assert property (@(posedge clk) disable iff (rst)
    chanState != 2'b11);

endmodule

// File: tb/rv_chan_monitor_tb.sv
module rv_chan_monitor_tb;

  localparam int DW = 8;
  localparam int CW = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          linkValid = 1'b0;
  logic          linkReady = 1'b0;
  logic [DW-1:0] linkData = '0;
  logic [1:0]    chanState;
  logic [CW-1:0] xferCount;
  logic [CW-1:0] waitCount;
  logic          dataErr;
  logic          validErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // scoreboard
  int       eXfer = 0;
  int       eWait = 0;
  bit       eDErr = 0;
  bit       eVErr = 0;
  bit       ePend = 0;
  logic [DW-1:0] eHeld = '0;

  always #5 clk = ~clk;

  rv_chan_monitor #(.DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .linkValid(linkValid), .linkReady(linkReady),
    .linkData(linkData), .chanState(chanState), .xferCount(xferCount),
    .waitCount(waitCount), .dataErr(dataErr), .validErr(validErr)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkRegs(input string tag);
    check(xferCount == CW'(eXfer), tag, "xferCount", xferCount, eXfer);
    check(waitCount == CW'(eWait), tag, "waitCount", waitCount, eWait);
    check(dataErr == eDErr, tag, "dataErr", dataErr, eDErr);
    check(validErr == eVErr, tag, "validErr", validErr, eVErr);
  endtask

  task automatic step(input bit v, input bit r, input logic [DW-1:0] d,
                      input string tag);
    int expState;
    @(negedge clk);
    linkValid = v; linkReady = r; linkData = d;
    #1;
    expState = (v && r) ? 2 : ((v && !r) ? 1 : 0);
    check(chanState == 2'(expState), tag, "chanState", chanState, expState);
    if (v && r && eXfer < MAXC) eXfer++;
    if (v && !r && eWait < MAXC) eWait++;
    if (ePend && v && d != eHeld) eDErr = 1;
    if (ePend && !v) eVErr = 1;
    if (v && !r) eHeld = d;
    ePend = v && !r;
    @(posedge clk); #1;
    checkRegs(tag);
  endtask

  task automatic doReset(input string tag);
    @(negedge clk);
    rst = 1'b1; linkValid = 1'b0; linkReady = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    eXfer = 0; eWait = 0; eDErr = 0; eVErr = 0; ePend = 0; eHeld = '0;
    #1;
    checkRegs(tag);
  endtask

  // R1: all four valid/ready combinations
  task automatic t_classify();
    step(0, 0, 8'h11, "R1");
    step(0, 1, 8'h12, "R1");
    step(1, 0, 8'h13, "R1");
    step(1, 1, 8'h13, "R1");
  endtask

  // R2: back-to-back transfers with changing data
  task automatic t_backToBack();
    for (int i = 0; i < 5; i++) step(1, 1, 8'(8'h20 + i), "R2");
    check(xferCount == CW'(eXfer), "R2", "burst total", xferCount, eXfer);
  endtask

  // R3: wait cycles counted, idle ignored
  task automatic t_waits();
    step(1, 0, 8'h31, "R3");
    step(1, 0, 8'h31, "R3");
    step(1, 0, 8'h31, "R3");
    step(1, 1, 8'h31, "R3");
    step(0, 1, 8'h00, "R3");
    step(0, 0, 8'h00, "R3");
  endtask

  // R5: valid raised before ready is legal
  task automatic t_earlyValid();
    step(1, 0, 8'h5A, "R5");
    step(1, 0, 8'h5A, "R5");
    step(1, 1, 8'h5A, "R5");
    check(!dataErr && !validErr, "R5", "no flag", dataErr | validErr, 0);
  endtask

  // R8: free change after handshake
  task automatic t_postXfer();
    step(1, 0, 8'h81, "R8");
    step(1, 1, 8'h81, "R8");
    step(1, 0, 8'h82, "R8");
    step(1, 1, 8'h82, "R8");
    step(0, 0, 8'h99, "R8");
    check(!dataErr && !validErr, "R8", "no flag", dataErr | validErr, 0);
  endtask

  // R6: data change during wait, then sticky
  task automatic t_dataChange();
    step(1, 0, 8'h61, "R6");
    step(1, 0, 8'h62, "R6");
    check(dataErr == 1'b1, "R6", "dataErr set", dataErr, 1);
    step(1, 1, 8'h62, "R6");
    step(0, 0, 8'h00, "R6");
    check(dataErr == 1'b1, "R6", "dataErr sticky", dataErr, 1);
    doReset("R9");
  endtask

  // R7: valid withdrawn during wait, no data flag
  task automatic t_validDrop();
    step(1, 0, 8'h71, "R7");
    step(0, 0, 8'h72, "R7");
    check(validErr == 1'b1 && dataErr == 1'b0, "R7", "validErr only",
          {dataErr, validErr}, 1);
    step(0, 1, 8'h00, "R7");
    check(validErr == 1'b1, "R7", "validErr sticky", validErr, 1);
    doReset("R9");
  endtask

  // R4: both counters saturate
  task automatic t_saturate();
    for (int i = 0; i < MAXC + 5; i++) step(1, 0, 8'h44, "R4");
    check(waitCount == CW'(MAXC), "R4", "waitCount full", waitCount, MAXC);
    for (int i = 0; i < MAXC + 5; i++) step(1, 1, 8'(i), "R4");
    check(xferCount == CW'(MAXC), "R4", "xferCount full", xferCount, MAXC);
  endtask

  // R9: reset drops a pending word
  task automatic t_resetPending();
    step(1, 0, 8'hA1, "R9");
    doReset("R9");
    step(1, 0, 8'hB2, "R9");
    check(!dataErr, "R9", "no stale compare", dataErr, 0);
    step(1, 1, 8'hB2, "R9");
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    checkRegs("R9");
    doReset("R9");
    t_classify();
    t_backToBack();
    t_waits();
    t_earlyValid();
    t_postXfer();
    t_dataChange();
    t_validDrop();
    t_saturate();
    doReset("R9");
    t_resetPending();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule